// File: doc/BRIEF.md
# Static Phase Shift Setting Calculator

This block turns a requested static phase offset for one divided PLL output into the two values that the output's counter needs. The first is a fine interpolator step, one of the eight legal positions 0, 4, ... 28 out of 32 per VCO period. The second is a coarse delay in whole VCO periods. The requested output phase and the feedback phase are given either in units of 45/8 degrees or in degrees with a fixed-point fraction. The feedback phase is subtracted from the output phase, because shifting the feedback counter moves every output the other way. A negative result is wrapped by adding 360 degrees.

The angle is then scaled by the output divide value into eighths of a VCO period, using a shift-add multiplier and a restoring divider that run over several cycles. Requests outside -360..+360 degrees are flagged as errors, and so are a divide value of zero and totals beyond the 256-period counter reach. Software or a configuration sequencer pulses `start`, waits for `done` and then reads the settings. The settings stay unchanged until the next request completes.

The control is a six-state machine:
- IDLE waits for `start`.
- CHECK validates the latched request. On an error it jumps straight to DONE; otherwise it loads the multiplier and moves to MUL.
- MUL runs the shift-add steps and then loads the divider on its last cycle before moving to DIV.
- DIV runs the restoring division steps and then moves to FIN.
- FIN applies the reach limit and registers the results, then moves to DONE.
- DONE pulses `done` for one cycle and returns to IDLE.

Top module: `phase_set_calc`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `err` are 0, and `pi_step` and `delay` are 0.
- R2: A `start` seen in IDLE latches all request inputs and raises `busy` from the next cycle on. `done` is high for exactly one cycle when the result is ready. `err`, `pi_step` and `delay` change only in a cycle where `done` is high, and they hold otherwise.
- R3: `start` has no effect while `busy` is high. This includes the cycle in which `done` is high. Such a request is neither latched nor answered.
- R4: When `unit_sel`=0, phases are signed integers in units of 45/8 degrees (64 = 360 degrees). When `unit_sel`=1, phases are signed degrees with FRAC=4 fraction bits (5760 = 360 degrees).
- R5: The net phase used is the output phase minus the feedback phase, in the selected unit.
- R6: A net phase in -360..0 (exclusive of 0) is converted by adding 360 degrees. A net phase of -360 yields zero settings.
- R7: total = floor(net*divide*8/360 + 1/2), in eighths of a VCO period. `delay` = total >> 3 and `pi_step` = (total mod 8)*4, so `pi_step` is always a multiple of 4 in 0..28.
- R8: A net phase above +360 or below -360 degrees gives `err`=1 with `pi_step`=0 and `delay`=0.
- R9: `divide`=0 gives `err`=1 with zero settings.
- R10: A total above 2055 (256 periods plus 7 eighths) gives `err`=1 with zero settings. Any total up to 2055 is accepted; for example, divide 256 at 360 degrees gives `delay`=256, `pi_step`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted in IDLE only |
| unit_sel | input | 1 | 0: units of 45/8 degrees, 1: fixed-point degrees |
| out_phase | input | 16 | Signed requested output phase |
| fb_phase | input | 16 | Signed feedback phase |
| divide | input | 10 | Output divide value |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request was rejected |
| pi_step | output | 5 | Fine interpolator step (multiple of 4) |
| delay | output | 9 | Coarse delay in whole VCO periods |

## Verification
The collision that matters is a new `start` arriving in the same cycle that `done` pulses for the previous request. The bench drives `start` with different inputs right in that cycle. It then checks that the machine drops back to idle, that no second `done` ever appears, and that the previous settings are unchanged. A `start` raised in the middle of a computation is judged the same way: the finished result must match the first request and not the intruding one. Rounding ties, the exact ±360 edges and the 2055/2056 reach boundary are placed so that a change of a single step is visible.

// File: rtl/phase_set_pkg.sv
package phase_set_pkg;
    // Counter reach in whole VCO periods
    localparam int unsigned MAX_DLY = 256;
    localparam int unsigned DLY_W   = $clog2(MAX_DLY + 1);
    localparam int unsigned STEP_W  = 5;
    // Largest total in eighths of a VCO period
    localparam int unsigned MAX_TOT = MAX_DLY * 8 + 7;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_MUL,
        S_DIV,
        S_FIN,
        S_DONE
    } calc_state_t;
endpackage

// File: rtl/phase_set_prep.sv
// Normalises both phases to fixed-point degrees, subtracts the feedback
// phase, range-checks and wraps negatives. FRAC must be at least 3.
module phase_set_prep #(
    parameter int PW   = 16,
    parameter int FRAC = 4,
    parameter int DW   = 10,
    localparam int IW   = PW + FRAC + 4,
    localparam int FULL = 360 << FRAC,
    localparam int AW   = $clog2(FULL + 1)
) (
    input  logic          unit_sel,
    input  logic [PW-1:0] out_phase,
    input  logic [PW-1:0] fb_phase,
    input  logic [DW-1:0] divide,
    output logic [AW-1:0] mag,
    output logic          range_err
);
    logic signed [IW-1:0] o_ext, f_ext, o_q, f_q;
    logic signed [IW:0]   net, hi_lim, lo_lim;

    always_comb begin
        o_ext  = {{(IW-PW){out_phase[PW-1]}}, out_phase};
        f_ext  = {{(IW-PW){fb_phase[PW-1]}},  fb_phase};
        if (unit_sel) begin
            o_q = o_ext;
            f_q = f_ext;
        end else begin
            o_q = (o_ext * $signed(IW'(45))) <<< (FRAC - 3);
            f_q = (f_ext * $signed(IW'(45))) <<< (FRAC - 3);
        end
        net       = $signed({o_q[IW-1], o_q}) - $signed({f_q[IW-1], f_q});
        hi_lim    = $signed((IW+1)'(FULL));
        lo_lim    = -hi_lim;
        range_err = (net > hi_lim) || (net < lo_lim) || (divide == '0);
        if (net[IW])
            mag = net[AW-1:0] + AW'(FULL);
        else
            mag = net[AW-1:0];
    end
endmodule

// File: rtl/phase_set_mul.sv
// Shift-add multiplier: one partial product per step.
module phase_set_mul #(
    parameter int AW = 13,
    parameter int DW = 10,
    localparam int PW = AW + DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [PW-1:0] prod
);
    logic [PW-1:0] mcand;
    logic [DW-1:0] mplier;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod   <= '0;
            mcand  <= '0;
            mplier <= '0;
        end else if (load) begin
            prod   <= '0;
            mcand  <= PW'(a);
            mplier <= b;
        end else if (step) begin
            if (mplier[0])
                prod <= prod + mcand;
            mcand  <= mcand << 1;
            mplier <= mplier >> 1;
        end
    end
endmodule

// File: rtl/phase_set_div.sv
// Restoring divider by a fixed denominator: one quotient bit per step.
module phase_set_div #(
    parameter int NW  = 27,
    parameter int DEN = 5760,
    localparam int DVW = $clog2(DEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [NW-1:0] dividend,
    output logic [NW-1:0] quo
);
    logic [DVW-1:0] rem;
    logic [DVW:0]   sh;
    logic           ge;

    always_comb begin
        sh = {rem, quo[NW-1]};
        ge = (sh >= (DVW+1)'(DEN));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0;
            quo <= '0;
        end else if (load) begin
            rem <= '0;
            quo <= dividend;
        end else if (step) begin
            rem <= ge ? DVW'(sh - (DVW+1)'(DEN)) : sh[DVW-1:0];
            quo <= {quo[NW-2:0], ge};
        end
    end

    // R7
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rem < DVW'(DEN));
endmodule

// File: rtl/phase_set_calc.sv
module phase_set_calc
    import phase_set_pkg::*;
#(
    parameter int PW   = 16,
    parameter int FRAC = 4,
    parameter int DW   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              unit_sel,
    input  logic [PW-1:0]     out_phase,
    input  logic [PW-1:0]     fb_phase,
    input  logic [DW-1:0]     divide,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [STEP_W-1:0] pi_step,
    output logic [DLY_W-1:0]  delay
);
    localparam int FULL = 360 << FRAC;
    localparam int HALF = FULL / 2;
    localparam int AW   = $clog2(FULL + 1);
    localparam int MW   = AW + DW;
    localparam int PRW  = AW + DW + 4;
    localparam int CW   = $clog2(PRW + 1);

    calc_state_t     state, nxt;
    logic [CW-1:0]   cnt;
    logic            lat_unit;
    logic [PW-1:0]   lat_out, lat_fb;
    logic [DW-1:0]   lat_div;
    logic [AW-1:0]   mag;
    logic            prep_err;
    logic [MW-1:0]   prod;
    logic [PRW-1:0]  dividend, total;
    logic            mul_load, mul_step, div_load, div_step, too_far;

    phase_set_prep #(.PW(PW), .FRAC(FRAC), .DW(DW)) u_prep (
        .unit_sel (lat_unit),
        .out_phase(lat_out),
        .fb_phase (lat_fb),
        .divide   (lat_div),
        .mag      (mag),
        .range_err(prep_err)
    );

    assign mul_load = (state == S_CHECK);
    assign mul_step = (state == S_MUL) && (cnt < CW'(DW));
    assign div_load = (state == S_MUL) && (cnt == CW'(DW));
    assign div_step = (state == S_DIV);
    assign dividend = PRW'({prod, 3'b000}) + PRW'(HALF);
    assign too_far  = (total > PRW'(MAX_TOT));

    phase_set_mul #(.AW(AW), .DW(DW)) u_mul (
        .clk  (clk),
        .rst_n(rst_n),
        .load (mul_load),
        .step (mul_step),
        .a    (mag),
        .b    (lat_div),
        .prod (prod)
    );

    phase_set_div #(.NW(PRW), .DEN(FULL)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (div_load),
        .step    (div_step),
        .dividend(dividend),
        .quo     (total)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = S_CHECK;
            S_CHECK: nxt = prep_err ? S_DONE : S_MUL;
            S_MUL:   if (cnt == CW'(DW)) nxt = S_DIV;
            S_DIV:   if (cnt == CW'(PRW - 1)) nxt = S_FIN;
            S_FIN:   nxt = S_DONE;
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // Request latch, step counter and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_unit <= 1'b0;
            lat_out  <= '0;
            lat_fb   <= '0;
            lat_div  <= '0;
            cnt      <= '0;
            err      <= 1'b0;
            pi_step  <= '0;
            delay    <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        lat_unit <= unit_sel;
                        lat_out  <= out_phase;
                        lat_fb   <= fb_phase;
                        lat_div  <= divide;
                    end
                end
                S_CHECK: begin
                    cnt <= '0;
                    if (prep_err) begin
                        err     <= 1'b1;
                        pi_step <= '0;
                        delay   <= '0;
                    end
                end
                S_MUL: cnt <= (cnt == CW'(DW)) ? '0 : cnt + 1'b1;
                S_DIV: cnt <= cnt + 1'b1;
                S_FIN: begin
                    err <= too_far;
                    if (too_far) begin
                        pi_step <= '0;
                        delay   <= '0;
                    end else begin
                        pi_step <= {total[2:0], 2'b00};
                        delay   <= total[3 +: DLY_W];
                    end
                end
                S_DONE: ;
                default: ;
            endcase
        end
    end

    assign busy = (state != S_IDLE);
    assign done = (state == S_DONE);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(pi_step) || !$stable(delay) || !$stable(err)) |-> done);
    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    // R7
    step_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pi_step[1:0] == 2'b00);
    // R8
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (pi_step == '0 && delay == '0));
    // R10
    delay_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        delay <= DLY_W'(MAX_DLY));
endmodule

// File: tb/sim_phase_set_calc.sv
`timescale 1ns/1ps
module sim_phase_set_calc;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              unit_sel = 1'b0;
    logic [15:0]       out_phase = '0;
    logic [15:0]       fb_phase = '0;
    logic [9:0]        divide = '0;
    logic              busy, done, err;
    logic [4:0]        pi_step;
    logic [8:0]        delay;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    phase_set_calc u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .unit_sel(unit_sel),
        .out_phase(out_phase), .fb_phase(fb_phase), .divide(divide),
        .busy(busy), .done(done), .err(err), .pi_step(pi_step), .delay(delay)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic issue(input bit u, input int op, input int fp, input int dv);
        @(negedge clk);
        unit_sel  = u;
        out_phase = 16'(op);
        fb_phase  = 16'(fp);
        divide    = 10'(dv);
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(req, "done seen", int'(done), 1);
    endtask

    task automatic expect_res(input string req, input int e_err, input int e_step, input int e_dly);
        chk(req, "err", int'(err), e_err);
        chk(req, "pi_step", int'(pi_step), e_step);
        chk(req, "delay", int'(delay), e_dly);
    endtask

    task automatic run(input string req, input bit u, input int op, input int fp, input int dv,
                       input int e_err, input int e_step, input int e_dly);
        issue(u, op, fp, dv);
        wait_done(req);
        expect_res(req, e_err, e_step, e_dly);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", int'(busy), 0);
        chk("R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after reset", int'(busy), 0);
        expect_res("R1", 0, 0, 0);
    endtask

    task automatic t_handshake();
        issue(1'b0, 16, 0, 1);
        chk("R2", "busy after start", int'(busy), 1);
        wait_done("R2");
        expect_res("R2", 0, 8, 0);
        @(negedge clk);
        chk("R2", "done one cycle", int'(done), 0);
        chk("R2", "busy cleared", int'(busy), 0);
        repeat (5) @(negedge clk);
        expect_res("R2 hold", 0, 8, 0);
    endtask

    task automatic t_units();
        // R4 unit 45/8 deg: 180 deg (32) div 2 -> total 8
        run("R4", 1'b0, 32, 0, 2, 0, 0, 1);
        // R4 fixed-point degrees: 100.5 deg (1608) div 3 -> total 7
        run("R4", 1'b1, 1608, 0, 3, 0, 28, 0);
        // R7 exact 360 deg, divide 1 -> one full period
        run("R7", 1'b0, 64, 0, 1, 0, 0, 1);
    endtask

    task automatic t_rounding();
        // R7 22.5 deg div 1 -> 0.5 eighth rounds up to 1
        run("R7 tie", 1'b1, 360, 0, 1, 0, 4, 0);
        // R7 just below the tie rounds down
        run("R7 below", 1'b1, 359, 0, 1, 0, 0, 0);
    endtask

    task automatic t_feedback();
        // R5 112.5 - (-22.5) = 135 deg, div 3 -> total 9
        run("R5", 1'b0, 20, -4, 3, 0, 4, 1);
        // R5 R6 0 - 45 = -45 -> 315 deg div 1 -> total 7
        run("R6", 1'b0, 0, 8, 1, 0, 28, 0);
        // R6 10 - 30 deg = -20 -> 340 deg, div 4 -> total 30
        run("R6", 1'b1, 160, 480, 4, 0, 24, 3);
        // R6 exactly -360 -> zero settings, no error
        run("R6 edge", 1'b0, -64, 0, 5, 0, 0, 0);
    endtask

    task automatic t_range();
        run("R8 high", 1'b0, 65, 0, 1, 1, 0, 0);
        run("R8 low", 1'b0, -40, 30, 1, 1, 0, 0);
        run("R9", 1'b0, 16, 0, 0, 1, 0, 0);
        // a good request after an error clears the flag
        run("R8 clear", 1'b0, 8, 0, 1, 0, 4, 0);
    endtask

    task automatic t_reach();
        run("R10 256", 1'b0, 64, 0, 256, 0, 0, 256);
        run("R10 257", 1'b0, 64, 0, 257, 1, 0, 0);
        run("R10 300", 1'b1, 3840, 0, 300, 0, 0, 200);
    endtask

    task automatic t_ignore();
        int extra = 0;
        // start during computation must not disturb the 135 deg request
        issue(1'b0, 20, -4, 3);
        repeat (4) @(negedge clk);
        unit_sel = 1'b0; out_phase = 16'(32); fb_phase = '0; divide = 10'(2);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R3");
        expect_res("R3 mid", 0, 4, 1);
        // start in the done cycle itself
        out_phase = 16'(16); fb_phase = '0; divide = 10'(1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R3", "idle after done-cycle start", int'(busy), 0);
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R3", "no extra done", extra, 0);
        expect_res("R3 done-cycle", 0, 4, 1);
    endtask

    initial begin
        t_reset();
        t_handshake();
        t_units();
        t_rounding();
        t_feedback();
        t_range();
        t_reach();
        t_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule